// File: doc/BRIEF.md
# Ping-pong LIFO Sample Reverser

This block produces the time-reversed copy of a sample stream that a symmetric FIR needs on its second data path. It holds two stacks of equal depth. At any moment one stack takes samples from the forward path and the other hands its contents, newest first, to the reverse path. A registered transfer control makes the two stacks trade roles. The trade happens on a high-to-low change only, so a whole block of samples is committed at once. New samples can then fill the other stack while the committed block is read out.

Samples move only on cycles when the active-low shift enable is asserted. A disable input turns reversal off: the reverse output then carries the forward sample, delayed by one register. The stacks keep running underneath. This is the setting for matrix-vector products, where the data set is committed with a one-cycle low pulse of the transfer control after its last sample.

Top module: `lifo_reverser`

## Requirements
- R1: After reset, `rev_sample` is 0, stack 0 is the receiving stack and both stacks are empty, so a pop before any swap returns 0.
- R2: While `fwd_shift_n` is high, no sample is pushed or popped and `rev_sample` holds its value.
- R3: On each cycle with `fwd_shift_n` low, `fwd_sample` is pushed onto the receiving stack. Once that stack holds DEPTH entries, further pushes are dropped and the stored entries are kept.
- R4: On each cycle with `fwd_shift_n` low and reversal enabled, the sending stack pops its most recent remaining entry. The entry appears on `rev_sample` after the rising edge of that cycle.
- R5: `swap_ctl` is sampled on every rising edge. The roles swap at an edge where the sampled value is low and the value sampled at the previous edge was high. Holding it low, or holding it high, causes no further swap.
- R6: In the cycle of a swap, both the push and the pop use the new roles. A sample shifted in goes to entry 0 of the new receiving stack, which is emptied by the swap. The pop takes the newest entry of the stack that was just filled.
- R7: A pop from an empty sending stack drives `rev_sample` to 0.
- R8: With `rev_disable` high, `rev_sample` takes `fwd_sample` on each cycle with `fwd_shift_n` low. Pushes, pops and swaps carry on unchanged, so after reversal is enabled again the output resumes with the correct stack entry.
- R9: Entries not yet popped from the sending stack are not disturbed by any number of pushes into the receiving stack. They stay in place until they are popped or the next swap discards them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwd_sample | input | SAMPLE_W (12) | Forward-path sample in two's complement |
| fwd_shift_n | input | 1 | Shift enable, active low; gates push, pop and output load |
| swap_ctl | input | 1 | Transfer control; a registered falling edge swaps the stack roles |
| rev_disable | input | 1 | High: output follows the forward input instead of the stack |
| rev_sample | output | SAMPLE_W (12) | Registered reverse-path sample |

## Verification
A wrong role select or a lost falling edge shows up on the first pop after the transfer pulse. `rev_sample` then carries the oldest sample, or a value from the previous block, where the newest one is expected. A count that is off by one shows within one shift cycle as a neighbouring sample, or a zero appears one pop early or late at the end of a block. A receive count that wraps past full is seen only when that block is popped. The first sample read back is then a later one that overwrote an entry, instead of the DEPTH-th. The bench therefore fills past full and drains every committed block completely.

// File: rtl/lifo_rev_pkg.sv
package lifo_rev_pkg;

   // Which of the two stacks currently receives forward samples
   typedef enum logic {
      STK_ZERO = 1'b0,
      STK_ONE  = 1'b1
   } stk_id_e;

   function automatic stk_id_e other_stack(input stk_id_e s);
      return (s == STK_ZERO) ? STK_ONE : STK_ZERO;
   endfunction

endpackage

// File: rtl/lifo_rev_edge.sv
module lifo_rev_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl,
   output logic ctl_q,
   output logic fall
);

   // Sampled copy of the control; reset low so that a high must be seen first
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= 1'b0;
      else        ctl_q <= ctl;
   end

   // Fall is flagged for the edge at which the control is sampled low after a high
   assign fall = ctl_q & ~ctl;

endmodule

// File: rtl/lifo_rev_bank.sv
module lifo_rev_bank #(
   parameter int W     = 12,
   parameter int DEPTH = 32,
   parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];

endmodule

// File: rtl/lifo_rev_ctrl.sv
module lifo_rev_ctrl
   import lifo_rev_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_act,
   input  logic          swap,
   output stk_id_e       recv_now,
   output stk_id_e       send_now,
   output logic          push_en,
   output logic [AW-1:0] push_addr,
   output logic          pop_valid,
   output logic [AW-1:0] pop_addr,
   output stk_id_e       recv_state,
   output logic [CW-1:0] fill_state,
   output logic [CW-1:0] left_state
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);
   localparam logic [CW-1:0] ONE  = CW'(1);

   stk_id_e       recv_q;
   logic [CW-1:0] fill_q, left_q;
   logic [CW-1:0] fill_eff, left_eff, fill_nx, left_nx, pop_idx;

   // A swap empties the new receiving stack and arms the freshly filled one
   always_comb begin
      recv_now  = swap ? other_stack(recv_q) : recv_q;
      send_now  = other_stack(recv_now);
      fill_eff  = swap ? '0 : fill_q;
      left_eff  = swap ? fill_q : left_q;
      push_en   = shift_act && (fill_eff != FULL);
      pop_valid = shift_act && (left_eff != '0);
      pop_idx   = left_eff - ONE;
      push_addr = fill_eff[AW-1:0];
      pop_addr  = pop_idx[AW-1:0];
      fill_nx   = push_en   ? fill_eff + ONE : fill_eff;
      left_nx   = pop_valid ? pop_idx        : left_eff;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         recv_q <= STK_ZERO;
         fill_q <= '0;
         left_q <= '0;
      end else begin
         recv_q <= recv_now;
         fill_q <= fill_nx;
         left_q <= left_nx;
      end
   end

   assign recv_state = recv_q;
   assign fill_state = fill_q;
   assign left_state = left_q;

endmodule

// File: rtl/lifo_reverser.sv
module lifo_reverser
   import lifo_rev_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int DEPTH    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] fwd_sample,
   input  logic                fwd_shift_n,
   input  logic                swap_ctl,
   input  logic                rev_disable,
   output logic [SAMPLE_W-1:0] rev_sample
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (SAMPLE_W < 1) begin : g_bad_width
         $error("lifo_reverser: SAMPLE_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("lifo_reverser: DEPTH must be at least 2");
      end
   endgenerate

   logic                shift_act;
   logic                ctl_q, swap;
   stk_id_e             recv_now, send_now, recv_st;
   logic                push_en, pop_valid;
   logic [AW-1:0]       push_addr, pop_addr;
   logic [CW-1:0]       fill_st, left_st;
   logic [SAMPLE_W-1:0] bank_rd [2];
   logic [SAMPLE_W-1:0] pop_data;

   assign shift_act = ~fwd_shift_n;

   lifo_rev_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (swap_ctl),
      .ctl_q (ctl_q),
      .fall  (swap)
   );

   lifo_rev_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_act  (shift_act),
      .swap       (swap),
      .recv_now   (recv_now),
      .send_now   (send_now),
      .push_en    (push_en),
      .push_addr  (push_addr),
      .pop_valid  (pop_valid),
      .pop_addr   (pop_addr),
      .recv_state (recv_st),
      .fill_state (fill_st),
      .left_state (left_st)
   );

   // Two identical stacks; write enable follows the receiving role
   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic we_b;
      assign we_b = push_en && (recv_now == stk_id_e'(b));
      lifo_rev_bank #(.W(SAMPLE_W), .DEPTH(DEPTH), .AW(AW)) u_bank (
         .clk   (clk),
         .we    (we_b),
         .waddr (push_addr),
         .wdata (fwd_sample),
         .raddr (pop_addr),
         .rdata (bank_rd[b])
      );
   end

   assign pop_data = (send_now == STK_ONE) ? bank_rd[1] : bank_rd[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rev_sample <= '0;
      else if (shift_act)
         rev_sample <= rev_disable ? fwd_sample
                                   : (pop_valid ? pop_data : '0);
   end

endmodule

// File: rtl/lifo_rev_checker.sv
module lifo_rev_checker #(
   parameter int SAMPLE_W = 12,
   parameter int DEPTH    = 32,
   parameter int CW       = $clog2(DEPTH + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [SAMPLE_W-1:0] fwd_sample,
   input logic                fwd_shift_n,
   input logic                swap_ctl,
   input logic                rev_disable,
   input logic [SAMPLE_W-1:0] rev_sample,
   input logic                ctl_q,
   input logic                recv_st,
   input logic [CW-1:0]       fill_st,
   input logic [CW-1:0]       left_st
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);
   localparam logic [CW-1:0] ONE  = CW'(1);

   a_r5_swap_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q && !swap_ctl) |=> (recv_st != $past(recv_st)));

   a_r5_no_swap_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_q && !swap_ctl) |=> (recv_st == $past(recv_st)));

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fill_st <= FULL);

   a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_shift_n |=> $stable(rev_sample));

   a_r7_empty_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!fwd_shift_n && !rev_disable && !(ctl_q && !swap_ctl) && left_st == '0)
      |=> (rev_sample == '0));

   a_r8_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (!fwd_shift_n && rev_disable) |=> (rev_sample == $past(fwd_sample)));

   a_r4_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!fwd_shift_n && !(ctl_q && !swap_ctl) && left_st != '0)
      |=> (left_st == $past(left_st) - ONE));

endmodule

bind lifo_reverser lifo_rev_checker #(
   .SAMPLE_W (SAMPLE_W),
   .DEPTH    (DEPTH),
   .CW       (CW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fwd_sample  (fwd_sample),
   .fwd_shift_n (fwd_shift_n),
   .swap_ctl    (swap_ctl),
   .rev_disable (rev_disable),
   .rev_sample  (rev_sample),
   .ctl_q       (ctl_q),
   .recv_st     (recv_st),
   .fill_st     (fill_st),
   .left_st     (left_st)
);

// File: tb/lifo_reverser_tb.sv
module lifo_reverser_tb_top;

   localparam int W     = 12;
   localparam int DEPTH = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] fwd_sample = '0;
   logic         fwd_shift_n = 1'b1;
   logic         swap_ctl = 1'b0;
   logic         rev_disable = 1'b0;
   logic [W-1:0] rev_sample;

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_tag  = "R1";

   always #4 clk = ~clk;   // 125 MHz

   lifo_reverser #(.SAMPLE_W(W), .DEPTH(DEPTH)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .fwd_sample  (fwd_sample),
      .fwd_shift_n (fwd_shift_n),
      .swap_ctl    (swap_ctl),
      .rev_disable (rev_disable),
      .rev_sample  (rev_sample)
   );

   // Reference behaviour built from the requirements
   logic [W-1:0] m_mem [2][DEPTH];
   int           m_fill, m_left;
   bit           m_recv, m_ctlq;
   logic [W-1:0] m_out;

   function automatic bit m_fall(input bit q, input logic now);
      return q && !now;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_fill = 0; m_left = 0; m_recv = 0; m_ctlq = 0; m_out = '0;
      end else begin
         bit sw;
         int fl, lf;
         bit rcv;
         sw  = m_fall(m_ctlq, swap_ctl);
         rcv = sw ? !m_recv : m_recv;
         fl  = sw ? 0 : m_fill;
         lf  = sw ? m_fill : m_left;
         if (!fwd_shift_n) begin
            logic [W-1:0] popped;
            popped = '0;
            if (lf > 0) begin
               popped = m_mem[!rcv][lf-1];
               lf = lf - 1;
            end
            m_out = rev_disable ? fwd_sample : popped;
            if (fl < DEPTH) begin
               m_mem[rcv][fl] = fwd_sample;
               fl = fl + 1;
            end
         end
         m_recv = rcv; m_fill = fl; m_left = lf; m_ctlq = swap_ctl;
      end
   end

   task automatic check_out();
      n_checks++;
      if (rev_sample !== m_out) begin
         n_errors++;
         $display("FAIL %s: rev_sample=%h expected %h", cur_tag, rev_sample, m_out);
      end
   endtask

   // Check the result of the previous cycle, then drive the next one
   task automatic step(input bit sn, input logic [W-1:0] d, input bit x,
                       input bit bp, input string tag);
      @(negedge clk);
      check_out();
      fwd_shift_n = sn; fwd_sample = d; swap_ctl = x; rev_disable = bp;
      cur_tag = tag;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      int seed;
      seed = 32'h5a17;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset value and empty stacks
      step(1, 12'h0, 0, 0, "R1");
      step(0, 12'h0, 0, 0, "R1");
      // R3: fill stack with distinct samples
      for (int i = 1; i <= 5; i++) step(0, W'(12'h100 + i), 0, 0, "R3");
      // R2: idle cycles leave everything still
      for (int i = 0; i < 3; i++) step(1, 12'hfff, 0, 0, "R2");
      // R5: raise, drop, hold low
      step(1, 12'h0, 1, 0, "R5");
      step(1, 12'h0, 0, 0, "R5");
      for (int i = 0; i < 4; i++) step(1, 12'h0, 0, 0, "R5");
      // R4: pop newest first while pushing
      for (int i = 0; i < 3; i++) step(0, W'(12'h200 + i), 0, 0, "R4");
      // R9: more pushes do not disturb what remains
      for (int i = 0; i < 3; i++) step(0, W'(12'h300 + i), 0, 0, "R9");
      step(1, 12'h0, 0, 0, "R9");
      // R7: drain past empty
      for (int i = 0; i < 4; i++) step(0, W'(12'h400 + i), 0, 0, "R7");
      // R6: swap cycle with shift active
      step(0, 12'h511, 1, 0, "R6");
      step(0, 12'h522, 0, 0, "R6");
      step(0, 12'h533, 0, 0, "R6");
      // R3: overfill, then swap and drain fully
      for (int i = 0; i < DEPTH + 4; i++) step(0, W'(12'h600 + i), 0, 0, "R3");
      step(1, 12'h0, 1, 0, "R3");
      for (int i = 0; i < DEPTH + 2; i++) step(0, W'(12'h700 + i), 0, 0, "R3");
      // R8: bypass while stacks keep moving, then back to reversal
      step(1, 12'h0, 0, 0, "R8");
      for (int i = 0; i < DEPTH; i++) step(0, W'(12'h800 + i), 0, 0, "R8");
      step(1, 12'h0, 1, 0, "R8");
      for (int i = 0; i < 3; i++) step(0, W'($urandom), 0, 1, "R8");
      for (int i = 0; i < DEPTH; i++) step(0, W'(12'h900 + i), 0, 0, "R8");
      // Random mix
      begin
         bit x;
         x = 0;
         for (int i = 0; i < 4000; i++) begin
            if ($urandom % 8 == 0) x = !x;
            step(($urandom % 4) == 0, W'($urandom), x, ($urandom % 16) == 0, "R4");
         end
      end
      step(1, 12'h0, 0, 0, "R2");
      finish_run();
   end

endmodule